// File: doc/BRIEF.md
# Vectored Interrupt Peripheral with Processor Acknowledge Model

The block pairs a small interrupting peripheral with a cycle-level model of the processor side that services it. The peripheral latches a data word when its input strobe pulses and holds it in a register that the system bus reads at a fixed address. It then raises an interrupt request towards the processor. The processor model runs instructions of a fixed length and samples the request only at the end of each instruction. When it sees the request, it saves its program counter and raises an acknowledge for one cycle. During that cycle the peripheral places its service address on the shared read-data bus, and the processor jumps to it.

A control register selects how the service address is delivered. In direct mode the bus carries the full ISR address. In table mode it carries a small index, which the processor turns into an entry of an evenly spaced address table. The same control register holds an enable bit that masks the request without discarding it. A data word that arrives while an earlier one is still unread sets an overrun flag. The request drops only after the data register is read. A return pulse from the ISR resumes execution at the saved program counter plus one.

Peripheral states: `P_IDLE` (nothing held), `P_PEND` (data held, request raised), `P_VEC` (vector delivered, waiting for the data read). Its transitions:
- strobe: `P_IDLE`→`P_PEND`, `P_VEC`→`P_PEND`
- acknowledge: `P_PEND`→`P_VEC`
- data read: `P_PEND`→`P_IDLE`, `P_VEC`→`P_IDLE`

Processor states: `C_EXEC` (executing), `C_ACK` (acknowledge cycle, vector captured), `C_ISR` (in service routine). Its transitions:
- request seen at the end of an instruction: `C_EXEC`→`C_ACK`
- always, one cycle later: `C_ACK`→`C_ISR`
- return pulse: `C_ISR`→`C_EXEC`

Top module: `vec_irq_sys`

## Requirements
- R1: After reset `irq_int`, `irq_ack`, `vec_drive` and `overrun` are 0, `pc` is RESET_PC (100), and `bus_rdata` is 0 while no read is selected.
- R2: A `din_stb` pulse latches `din`. With the enable set, `irq_int` is 1 from the next clock edge. A read (`bus_sel`=1, `bus_we`=0) of address 0x8000 returns the latched word on `bus_rdata` in the same cycle.
- R3: In `C_EXEC` each instruction lasts INSTR_CYC (4) cycles and `pc` steps by one at its end. `irq_ack` rises only on the edge that ends an instruction during which `irq_int` was 1, and never earlier.
- R4: In direct mode (control bit 1 = 0), `bus_rdata` equals VEC_ADDR (16) and `vec_drive` is 1 while `irq_ack` is 1, and `pc` equals 16 on the next edge.
- R5: In table mode (control bit 1 = 1), the bus carries TBL_INDEX (5) during the acknowledge, and `pc` becomes TBL_BASE + index × TBL_STRIDE (0x200 + 5×4 = 0x214).
- R6: `irq_int` stays 1 through and after the acknowledge until the data register is read, and it is 0 from the edge that performs that read.
- R7: `vec_drive` is 0 whenever `irq_ack` is 0.
- R8: Writing 0 to control bit 0 (address 0x8001) forces `irq_int` to 0 and keeps the request pending. Writing 1 back raises `irq_int` on the next edge with no new strobe.
- R9: A strobe while a word is still unread sets `overrun` and replaces the held word. A data read clears `overrun`.
- R10: A pulse on `isr_ret` in `C_ISR` sets `pc` to the saved value plus one on the next edge, and execution resumes.
- R11: `irq_ack` is high for exactly one cycle per service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | DW | Arriving data word |
| din_stb | input | 1 | One-cycle strobe that latches `din` |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Bus address (0x8000 data, 0x8001 control) |
| bus_wdata | input | DW | Write data (control: bit 0 enable, bit 1 table mode) |
| bus_rdata | output | DW | Read data, or the vector/index during acknowledge |
| irq_int | output | 1 | Interrupt request to the processor |
| irq_ack | output | 1 | Processor acknowledge |
| vec_drive | output | 1 | Peripheral drives the vector on the bus |
| overrun | output | 1 | Data arrived while the previous word was unread |
| isr_ret | input | 1 | Return-from-ISR pulse |
| pc | output | PCW | Program counter of the processor model |

## Verification
The bench drives and samples on falling edges. A result registered on a rising edge is therefore checked at the falling edge that follows it. `irq_int` is checked one edge after the strobe or the control write. `irq_ack` is checked exactly four edges after the instruction boundary to which the strobe was aligned, and the jump target one edge after that. The bench finds that boundary by waiting for `pc` to step. Read data is sampled combinationally within the read cycle. The drop of the request and the return address are each checked at the falling edge right after the read or return pulse.

// File: rtl/virq_pkg.sv
package virq_pkg;

    typedef enum logic [1:0] {
        P_IDLE = 2'd0,
        P_PEND = 2'd1,
        P_VEC  = 2'd2
    } per_state_t;

    typedef enum logic [1:0] {
        C_EXEC = 2'd0,
        C_ACK  = 2'd1,
        C_ISR  = 2'd2
    } cpu_state_t;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_TBL_BIT = 1;
    localparam int CTRL_OVR_BIT = 2;

endpackage

// File: rtl/virq_periph.sv
module virq_periph
    import virq_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 16,
    parameter int DATA_ADDR = 16'h8000,
    parameter int CTRL_ADDR = 16'h8001,
    parameter int VEC_ADDR  = 16,
    parameter int TBL_INDEX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          din_stb,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          inta_i,
    output logic [DW-1:0] rdata_o,
    output logic          drive_o,
    output logic          irq_o,
    output logic          table_mode_o,
    output logic          overrun_o
);

    localparam logic [AW-1:0] DATA_A = AW'(DATA_ADDR);
    localparam logic [AW-1:0] CTRL_A = AW'(CTRL_ADDR);
    localparam logic [DW-1:0] VEC_W  = DW'(VEC_ADDR);
    localparam logic [DW-1:0] IDX_W  = DW'(TBL_INDEX);

    per_state_t    state_q, state_d;
    logic [DW-1:0] data_q;
    logic          ovr_q;
    logic          en_q;
    logic          tbl_q;

    logic rd_data_hit;
    logic rd_ctrl_hit;
    logic wr_ctrl_hit;
    logic held;

    assign rd_data_hit = bus_sel && !bus_we && !inta_i && (bus_addr == DATA_A);
    assign rd_ctrl_hit = bus_sel && !bus_we && !inta_i && (bus_addr == CTRL_A);
    assign wr_ctrl_hit = bus_sel && bus_we && (bus_addr == CTRL_A);
    assign held        = (state_q != P_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_IDLE: begin
                if (din_stb) state_d = P_PEND;
            end
            P_PEND: begin
                if (din_stb)          state_d = P_PEND;
                else if (rd_data_hit) state_d = P_IDLE;
                else if (inta_i)      state_d = P_VEC;
            end
            P_VEC: begin
                if (din_stb)          state_d = P_PEND;
                else if (rd_data_hit) state_d = P_IDLE;
            end
            default: state_d = P_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
            en_q   <= 1'b1;
            tbl_q  <= 1'b0;
        end else begin
            if (din_stb) data_q <= din;
            if (din_stb && held && !rd_data_hit) ovr_q <= 1'b1;
            else if (rd_data_hit)                ovr_q <= 1'b0;
            if (wr_ctrl_hit) begin
                en_q  <= bus_wdata[CTRL_EN_BIT];
                tbl_q <= bus_wdata[CTRL_TBL_BIT];
            end
        end
    end

    // combinational outputs
    always_comb begin
        irq_o        = held && en_q;
        drive_o      = inta_i && held;
        table_mode_o = tbl_q;
        overrun_o    = ovr_q;
        rdata_o      = '0;
        if (drive_o) begin
            rdata_o = tbl_q ? IDX_W : VEC_W;
        end else if (rd_data_hit) begin
            rdata_o = data_q;
        end else if (rd_ctrl_hit) begin
            rdata_o[CTRL_EN_BIT]  = en_q;
            rdata_o[CTRL_TBL_BIT] = tbl_q;
            rdata_o[CTRL_OVR_BIT] = ovr_q;
        end
    end

    AST_INT_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (din_stb && en_q && !wr_ctrl_hit) |=> irq_o); // R2
    AST_INT_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_data_hit && !wr_ctrl_hit) |=> irq_o); // R6
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(din_stb && held)); // R9
    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_hit && !din_stb) |=> !overrun_o); // R9

endmodule

// File: rtl/virq_cpu_model.sv
module virq_cpu_model
    import virq_pkg::*;
#(
    parameter int DW         = 8,
    parameter int PCW        = 16,
    parameter int INSTR_CYC  = 4,
    parameter int RESET_PC   = 100,
    parameter int TBL_BASE   = 16'h0200,
    parameter int TBL_STRIDE = 4,
    parameter int TBL_DEPTH  = 256
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_i,
    input  logic           table_mode_i,
    input  logic [DW-1:0]  bus_i,
    input  logic           isr_ret_i,
    output logic           inta_o,
    output logic [PCW-1:0] pc_o
);

    localparam int             CW   = (INSTR_CYC > 1) ? $clog2(INSTR_CYC) : 1;
    localparam int             IDXW = (TBL_DEPTH > 1) ? $clog2(TBL_DEPTH) : 1;
    localparam logic [CW-1:0]  LAST = CW'(INSTR_CYC - 1);
    localparam logic [PCW-1:0] RPC  = PCW'(RESET_PC);

    cpu_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q;
    logic [PCW-1:0] pc_q;
    logic [PCW-1:0] saved_q;
    logic           at_end;

    assign at_end = (cnt_q == LAST);

    function automatic logic [PCW-1:0] isr_target(input logic [DW-1:0] v, input logic tbl);
        logic [IDXW-1:0] idx;
        idx = IDXW'(v);
        if (tbl) isr_target = PCW'(TBL_BASE) + PCW'(idx) * PCW'(TBL_STRIDE);
        else     isr_target = PCW'(v);
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_EXEC:  if (at_end && irq_i) state_d = C_ACK;
            C_ACK:   state_d = C_ISR;
            C_ISR:   if (isr_ret_i) state_d = C_EXEC;
            default: state_d = C_EXEC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_EXEC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pc_q    <= RPC;
            saved_q <= RPC;
        end else begin
            unique case (state_q)
                C_EXEC: begin
                    if (at_end) begin
                        cnt_q <= '0;
                        if (irq_i) saved_q <= pc_q;
                        else       pc_q    <= pc_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                C_ACK: begin
                    pc_q <= isr_target(bus_i, table_mode_i);
                end
                C_ISR: begin
                    if (isr_ret_i) begin
                        pc_q  <= saved_q + 1'b1;
                        cnt_q <= '0;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign inta_o = (state_q == C_ACK);
    assign pc_o   = pc_q;

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |=> !inta_o); // R11
    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inta_o) |-> $past(irq_i && at_end)); // R3
    AST_PC_HOLDS_MID_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_EXEC && !at_end) |=> $stable(pc_o)); // R3
    AST_RETURN_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == C_ISR && isr_ret_i) |=> (pc_o == $past(saved_q) + 1'b1)); // R10

endmodule

// File: rtl/vec_irq_sys.sv
module vec_irq_sys #(
    parameter int DW         = 8,
    parameter int AW         = 16,
    parameter int PCW        = 16,
    parameter int DATA_ADDR  = 16'h8000,
    parameter int CTRL_ADDR  = 16'h8001,
    parameter int VEC_ADDR   = 16,
    parameter int TBL_INDEX  = 5,
    parameter int TBL_BASE   = 16'h0200,
    parameter int TBL_STRIDE = 4,
    parameter int TBL_DEPTH  = 256,
    parameter int INSTR_CYC  = 4,
    parameter int RESET_PC   = 100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  din,
    input  logic           din_stb,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           irq_int,
    output logic           irq_ack,
    output logic           vec_drive,
    output logic           overrun,
    input  logic           isr_ret,
    output logic [PCW-1:0] pc
);

    logic table_mode;

    virq_periph #(
        .DW(DW), .AW(AW), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .VEC_ADDR(VEC_ADDR), .TBL_INDEX(TBL_INDEX)
    ) u_periph (
        .clk(clk), .rst_n(rst_n), .din(din), .din_stb(din_stb),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .inta_i(irq_ack), .rdata_o(bus_rdata),
        .drive_o(vec_drive), .irq_o(irq_int), .table_mode_o(table_mode),
        .overrun_o(overrun)
    );

    virq_cpu_model #(
        .DW(DW), .PCW(PCW), .INSTR_CYC(INSTR_CYC), .RESET_PC(RESET_PC),
        .TBL_BASE(TBL_BASE), .TBL_STRIDE(TBL_STRIDE), .TBL_DEPTH(TBL_DEPTH)
    ) u_cpu (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_int), .table_mode_i(table_mode),
        .bus_i(bus_rdata), .isr_ret_i(isr_ret), .inta_o(irq_ack), .pc_o(pc)
    );

    AST_VEC_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_drive |-> irq_ack); // R7
    AST_ACK_HAS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> vec_drive); // R4

endmodule

// File: tb/tb_vec_irq_sys.sv
module tb_vec_irq_sys;

    localparam int CLK_PERIOD = 10;
    localparam int INSTR      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = '0;
    logic        din_stb = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_int, irq_ack, vec_drive, overrun;
    logic        isr_ret = 1'b0;
    logic [15:0] pc;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_sys dut (
        .clk(clk), .rst_n(rst_n), .din(din), .din_stb(din_stb),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_int(irq_int),
        .irq_ack(irq_ack), .vec_drive(vec_drive), .overrun(overrun),
        .isr_ret(isr_ret), .pc(pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] d);
        din = d; din_stb = 1'b1;
        @(negedge clk);
        din_stb = 1'b0;
    endtask

    task automatic sync_pc();
        logic [15:0] prev;
        prev = pc;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pc != prev) break;
        end
    endtask

    task automatic wait_ack(output bit seen);
        seen = 0;
        for (int i = 0; i < INSTR + 2; i++) begin
            if (irq_ack) begin seen = 1; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 irq_int", irq_int, 0);
        chk("R1 irq_ack", irq_ack, 0);
        chk("R1 vec_drive", vec_drive, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 pc", pc, 100);
        chk("R1 rdata idle", bus_rdata, 0);
    endtask

    task automatic t_pacing();
        logic [15:0] p0;
        int n;
        sync_pc();
        p0 = pc; n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); n++;
            if (pc != p0) break;
        end
        chk("R3 cycles per instruction", n, INSTR);
        chk("R3 pc step", pc, p0 + 1);
    endtask

    task automatic t_direct();
        logic [15:0] p0;
        logic [7:0] d;
        sync_pc();
        p0 = pc;
        strobe(8'hA5);
        chk("R2 irq after strobe", irq_int, 1);
        chk("R9 no overrun single", overrun, 0);
        @(negedge clk); chk("R3 no early ack", irq_ack, 0);
        @(negedge clk); chk("R3 no early ack", irq_ack, 0);
        chk("R7 no drive without ack", vec_drive, 0);
        @(negedge clk);
        chk("R3 ack at boundary", irq_ack, 1);
        chk("R4 vector on bus", bus_rdata, 16);
        chk("R4 vec_drive", vec_drive, 1);
        chk("R3 pc held", pc, p0);
        @(negedge clk);
        chk("R11 ack one cycle", irq_ack, 0);
        chk("R7 drive off", vec_drive, 0);
        chk("R4 jump target", pc, 16);
        chk("R6 irq held after ack", irq_int, 1);
        bus_read(16'h8000, d);
        chk("R2 data read", d, 8'hA5);
        chk("R6 irq cleared by read", irq_int, 0);
        isr_ret = 1'b1;
        @(negedge clk);
        isr_ret = 1'b0;
        chk("R10 return pc", pc, p0 + 1);
        repeat (INSTR) @(negedge clk);
        chk("R10 resumed", pc, p0 + 2);
    endtask

    task automatic t_table();
        logic [15:0] p0;
        logic [7:0] d;
        bus_write(16'h8001, 8'h03);
        sync_pc();
        p0 = pc;
        strobe(8'h3C);
        repeat (3) @(negedge clk);
        chk("R5 ack", irq_ack, 1);
        chk("R5 index on bus", bus_rdata, 5);
        @(negedge clk);
        chk("R5 table target", pc, 16'h0214);
        bus_read(16'h8000, d);
        chk("R5 data", d, 8'h3C);
        isr_ret = 1'b1;
        @(negedge clk);
        isr_ret = 1'b0;
        chk("R10 return after table", pc, p0 + 1);
        bus_write(16'h8001, 8'h01);
    endtask

    task automatic t_mask();
        bit seen;
        bit any_ack;
        logic [7:0] d;
        bus_write(16'h8001, 8'h00);
        strobe(8'h77);
        chk("R8 masked irq", irq_int, 0);
        any_ack = 0;
        for (int i = 0; i < 3 * INSTR; i++) begin
            @(negedge clk);
            if (irq_ack) any_ack = 1;
        end
        chk("R8 no ack while masked", any_ack, 0);
        bus_write(16'h8001, 8'h01);
        chk("R8 irq after unmask", irq_int, 1);
        wait_ack(seen);
        chk("R8 pending serviced", seen, 1);
        chk("R4 vector after unmask", bus_rdata, 16);
        @(negedge clk);
        chk("R4 target after unmask", pc, 16);
        bus_read(16'h8000, d);
        chk("R8 data kept", d, 8'h77);
        isr_ret = 1'b1;
        @(negedge clk);
        isr_ret = 1'b0;
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        bus_write(16'h8001, 8'h00);
        strobe(8'h11);
        chk("R9 no overrun first", overrun, 0);
        strobe(8'h22);
        chk("R9 overrun set", overrun, 1);
        bus_read(16'h8000, d);
        chk("R9 latest data", d, 8'h22);
        chk("R9 overrun cleared", overrun, 0);
        bus_write(16'h8001, 8'h01);
        chk("R6 no request after read", irq_int, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pacing();
        t_direct();
        t_table();
        t_mask();
        t_overrun();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

endmodule